// File: doc/BRIEF.md
# Low-Power Mode and Clock Controller

This block chooses the operating mode of a small processor core and produces the clock enables that the rest of the core runs from. It is clocked by the high-speed RC oscillator. It samples the low-speed RC oscillator as a slow level and turns each rising edge of that level into a one-cycle tick. In the two running modes it issues a CPU clock enable. In FAST mode that enable comes from a power-of-two prescaler on the fast clock. In SLOW mode it comes from the low-speed ticks.

A HALT request from the CPU stops the CPU enable and moves the block into one of four standby modes. Two hold bits, read at the moment of the HALT, pick the mode. Each standby mode keeps a different set of oscillators running for the peripherals. A wake-up event returns the block to the running mode it left. When the high-speed oscillator is switched on it is not trusted straight away: FAST mode gives no CPU enable until a start-up count of low-speed ticks has elapsed.

Software sees two byte registers through a simple write strobe and a read mux. The first is the clock control register. The second is the fast-oscillator register.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode output is FAST (code 0), the clock control register reads 0x00 and the oscillator register reads 0x01 (enable set, ready clear).
- R2: reg_sel=0 addresses the clock control register: prescaler select in bits 7:5, hold-fast bit in bit 1, hold-slow bit in bit 0, with bits 4:2 reading zero whatever is written. reg_sel=1 addresses the oscillator register: enable in bit 0 (read/write), ready in bit 1 (read-only), bits 7:2 reading zero. Writing 0xFF to the first register reads back 0xE3, and writing 0xFE to the second reads back 0x00 once the oscillator is off.
- R3: With a select value n from 0 to 6, FAST mode gives exactly one cpu_ce pulse every 2^n clock cycles.
- R4: Select value 7 puts the block in SLOW mode (code 1), where cpu_ce pulses once per rising edge of the low-speed input.
- R5: Each time the fast oscillator is switched on, ready stays low until READY_TICKS low-speed rising edges have passed, and FAST mode produces no cpu_ce while ready is low. Switching the oscillator off clears ready.
- R6: hs_osc_en is high in FAST mode. In SLOW mode it follows the enable bit. In standby it is high only in IDLE1 and IDLE2.
- R7: HALT with hold-fast=0 and hold-slow=0 enters SLEEP (code 2). In SLEEP cpu_ce stays low, hs_osc_en is low and ls_osc_en follows wdt_en.
- R8: HALT with hold-fast=0 and hold-slow=1 enters IDLE0 (code 3). In IDLE0 ls_osc_en is high and hs_osc_en is low.
- R9: HALT with both hold bits set enters IDLE1 (code 4). In IDLE1 both oscillator enables are high and cpu_ce stays low.
- R10: HALT with hold-fast=1 and hold-slow=0 enters IDLE2 (code 5). In IDLE2 hs_osc_en is high and ls_osc_en follows wdt_en.
- R11: A wake-up event in standby restores the running mode that was left. In FAST mode with select n, the first cpu_ce appears after the 2^n-th clock edge that follows the edge capturing the wake-up, so for n=2 the enable is low for four samples and then high.
- R12: A wake-up event while running has no effect on the mode. A HALT request while in standby has no effect on the mode.
- R13: periph_hs_ce is high while the fast oscillator is required by the mode and ready is high, so it is high in IDLE2 and low in IDLE0. periph_ls_ce pulses on low-speed edges while the slow oscillator is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| lsc_in | input | 1 | Low-speed oscillator level, asynchronous |
| halt_req | input | 1 | One-cycle HALT request from the CPU |
| wake_evt | input | 1 | One-cycle wake-up event |
| wdt_en | input | 1 | Watchdog enabled; keeps the slow oscillator in SLEEP and IDLE2 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: clock control register, 1: oscillator register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| mode | output | 3 | Current mode code (0 FAST, 1 SLOW, 2 SLEEP, 3 IDLE0, 4 IDLE1, 5 IDLE2) |
| cpu_ce | output | 1 | CPU clock enable |
| hs_osc_en | output | 1 | Fast oscillator enable |
| ls_osc_en | output | 1 | Slow oscillator enable |
| periph_hs_ce | output | 1 | Peripheral fast clock enable |
| periph_ls_ce | output | 1 | Peripheral slow clock enable pulse |

## Verification
The bench keeps the default prescaler depth of 6, so the longest divide of 64 is measured over a window of two full periods. It overrides READY_TICKS to 4, which brings the start-up gating after reset and after leaving SLEEP within a few dozen cycles. The low-speed input is driven with a period of 10 clocks, so SLOW-mode pulse counts and the ready delay have exact expected values. Cycle-exact sampling after a wake-up with a divide of 4 pins down where the first CPU enable falls.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_SUB = 3'd7;

  typedef enum logic [2:0] {
    M_FAST  = 3'd0,
    M_SLOW  = 3'd1,
    M_SLEEP = 3'd2,
    M_IDLE0 = 3'd3,
    M_IDLE1 = 3'd4,
    M_IDLE2 = 3'd5
  } pwr_mode_e;
endpackage

// File: rtl/pcc_regs.sv
module pcc_regs
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             hs_ready,
  output logic [REG_W-1:0] rdata,
  output logic [SEL_W-1:0] div_sel,
  output logic             keep_hs,
  output logic             keep_ls,
  output logic             hs_en_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_sel   <= '0;
      keep_hs   <= 1'b0;
      keep_ls   <= 1'b0;
      hs_en_bit <= 1'b1;
    end else if (wr_en) begin
      if (!sel) begin
        div_sel <= wdata[REG_W-1 -: SEL_W];
        keep_hs <= wdata[1];
        keep_ls <= wdata[0];
      end else begin
        hs_en_bit <= wdata[0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!sel) begin
      rdata[REG_W-1 -: SEL_W] = div_sel;
      rdata[1] = keep_hs;
      rdata[0] = keep_ls;
    end else begin
      rdata[1] = hs_ready;
      rdata[0] = hs_en_bit;
    end
  end
endmodule

// File: rtl/pcc_lsc_sync.sv
module pcc_lsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lsc_in,
  output logic tick
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], lsc_in};
  end

  assign tick = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/pcc_prescaler.sv
module pcc_prescaler #(
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [MAX_LOG-1:0] cnt;
  logic [MAX_LOG-1:0] mask;

  always_comb begin
    for (int i = 0; i < MAX_LOG; i++) mask[i] = (i < int'(sel));
  end

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign tick = ((cnt & mask) == mask);
endmodule

// File: rtl/pcc_hs_ready.sv
module pcc_hs_ready #(
  parameter int READY_TICKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_on,
  input  logic lsc_tick,
  output logic ready
);
  localparam int CW = $clog2(READY_TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !osc_on) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready && lsc_tick) begin
      if (cnt == CW'(READY_TICKS - 1)) ready <= 1'b1;
      else                             cnt   <= cnt + 1'b1;
    end
  end

  p_ready_drop_r5: assert property (@(posedge clk) disable iff (rst)
    !osc_on |=> !ready);
  p_ready_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(lsc_tick));
endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic             wake,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             keep_hs,
  input  logic             keep_ls,
  output pwr_mode_e        mode,
  output logic             standby,
  output logic             restart
);
  pwr_mode_e ret_q, mode_nxt, ret_nxt, run_mode;

  assign standby  = (mode != M_FAST) && (mode != M_SLOW);
  assign run_mode = (div_sel == SEL_SUB) ? M_SLOW : M_FAST;
  assign restart  = standby && wake;

  always_comb begin
    mode_nxt = mode;
    ret_nxt  = ret_q;
    if (!standby) begin
      if (halt) begin
        ret_nxt = run_mode;
        case ({keep_hs, keep_ls})
          2'b00:   mode_nxt = M_SLEEP;
          2'b01:   mode_nxt = M_IDLE0;
          2'b11:   mode_nxt = M_IDLE1;
          default: mode_nxt = M_IDLE2;
        endcase
      end else begin
        mode_nxt = run_mode;
      end
    end else if (wake) begin
      mode_nxt = ret_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= M_FAST;
      ret_q <= M_FAST;
    end else begin
      mode  <= mode_nxt;
      ret_q <= ret_nxt;
    end
  end

  p_wake_return_r11: assert property (@(posedge clk) disable iff (rst)
    (standby && wake) |=> (mode == $past(ret_q)));
  p_halt_in_standby_r12: assert property (@(posedge clk) disable iff (rst)
    (standby && !wake) |=> $stable(mode));
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int MAX_LOG     = 6,
  parameter int READY_TICKS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lsc_in,
  input  logic             halt_req,
  input  logic             wake_evt,
  input  logic             wdt_en,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [2:0]       mode,
  output logic             cpu_ce,
  output logic             hs_osc_en,
  output logic             ls_osc_en,
  output logic             periph_hs_ce,
  output logic             periph_ls_ce
);
  logic [SEL_W-1:0] div_sel;
  logic keep_hs, keep_ls, hs_en_bit, hs_ready;
  logic lsc_tick, div_tick, standby, restart;
  logic hs_on_c, ls_on_c;
  pwr_mode_e mode_q;

  pcc_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .hs_ready(hs_ready), .rdata(reg_rdata), .div_sel(div_sel),
    .keep_hs(keep_hs), .keep_ls(keep_ls), .hs_en_bit(hs_en_bit)
  );

  pcc_lsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .lsc_in(lsc_in), .tick(lsc_tick)
  );

  pcc_prescaler #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_div (
    .clk(clk), .rst(rst), .restart(restart), .sel(div_sel), .tick(div_tick)
  );

  pcc_hs_ready #(.READY_TICKS(READY_TICKS)) u_rdy (
    .clk(clk), .rst(rst), .osc_on(hs_osc_en), .lsc_tick(lsc_tick),
    .ready(hs_ready)
  );

  pcc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .halt(halt_req), .wake(wake_evt),
    .div_sel(div_sel), .keep_hs(keep_hs), .keep_ls(keep_ls),
    .mode(mode_q), .standby(standby), .restart(restart)
  );

  assign mode = mode_q;

  always_comb begin
    case (mode_q)
      M_FAST, M_IDLE1, M_IDLE2: hs_on_c = 1'b1;
      M_SLOW:                   hs_on_c = hs_en_bit;
      default:                  hs_on_c = 1'b0;
    endcase
    case (mode_q)
      M_SLEEP, M_IDLE2: ls_on_c = wdt_en;
      default:          ls_on_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ce       <= 1'b0;
      hs_osc_en    <= 1'b1;
      ls_osc_en    <= 1'b1;
      periph_hs_ce <= 1'b0;
      periph_ls_ce <= 1'b0;
    end else begin
      cpu_ce       <= ((mode_q == M_FAST) && hs_ready && div_tick) ||
                      ((mode_q == M_SLOW) && lsc_tick);
      hs_osc_en    <= hs_on_c;
      ls_osc_en    <= ls_on_c;
      periph_hs_ce <= hs_on_c && hs_ready;
      periph_ls_ce <= ls_on_c && lsc_tick;
    end
  end

  p_cpu_quiet_standby_r7: assert property (@(posedge clk) disable iff (rst)
    (standby && $past(standby)) |-> !cpu_ce);
  p_fast_gated_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_FAST) && !hs_ready) |=> !cpu_ce);
  p_sleep_ls_off_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_SLEEP) && !wdt_en) |=> !ls_osc_en);
  p_idle1_both_on_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_IDLE1) |=> (hs_osc_en && ls_osc_en));
endmodule

// File: tb/pwr_clk_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_tb;
  localparam int K_MODE = 0, K_RD = 1, K_HS = 2, K_LS = 3, K_PHS = 4,
                 K_CPU = 5, K_CNT = 6;

  typedef struct {
    int    kind;
    int    exp;
    string req;
  } item_t;

  logic clk = 1'b0, rst = 1'b1, lsc_in = 1'b0;
  logic halt_req = 1'b0, wake_evt = 1'b0, wdt_en = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [2:0] mode;
  logic cpu_ce, hs_osc_en, ls_osc_en, periph_hs_ce, periph_ls_ce;

  int errors = 0, checks = 0, cpu_cnt = 0, lcnt = 0;
  logic cnt_clr = 1'b0, done = 1'b0;
  item_t q[$];
  event ev;

  pwr_clk_ctrl #(.READY_TICKS(4)) u_dut (
    .clk(clk), .rst(rst), .lsc_in(lsc_in), .halt_req(halt_req),
    .wake_evt(wake_evt), .wdt_en(wdt_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode(mode), .cpu_ce(cpu_ce),
    .hs_osc_en(hs_osc_en), .ls_osc_en(ls_osc_en),
    .periph_hs_ce(periph_hs_ce), .periph_ls_ce(periph_ls_ce)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (lcnt == 4) begin lcnt <= 0; lsc_in <= ~lsc_in; end
    else lcnt <= lcnt + 1;
  end

  always @(negedge clk) begin
    if (cnt_clr) cpu_cnt = 0;
    else if (cpu_ce) cpu_cnt = cpu_cnt + 1;
  end

  // monitor: pops expected items and compares with the outputs
  always begin
    @(ev);
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        K_MODE:  act = int'(mode);
        K_RD:    act = int'(reg_rdata);
        K_HS:    act = int'(hs_osc_en);
        K_LS:    act = int'(ls_osc_en);
        K_PHS:   act = int'(periph_hs_ce);
        K_CPU:   act = int'(cpu_ce);
        default: act = cpu_cnt;
      endcase
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input int exp, input string req);
    item_t it;
    #1;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    -> ev;
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic s, input int exp, input string req);
    @(negedge clk); reg_sel = s;
    chk(K_RD, exp, req);
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic count_win(input int n, input int exp, input string req);
    @(posedge clk); cnt_clr = 1'b1;
    @(posedge clk); cnt_clr = 1'b0;
    repeat (n) @(negedge clk);
    chk(K_CNT, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    // R1: reset state
    rd(1'b0, 8'h00, "R1");
    rd(1'b1, 8'h01, "R1");
    chk(K_MODE, 0, "R1");
    // R5: no CPU enable before the oscillator is ready
    count_win(15, 0, "R5");
    cyc(60);
    rd(1'b1, 8'h03, "R5");
    // R3: divide ratios
    count_win(32, 32, "R3");
    wr(1'b0, 8'h40); cyc(2);
    count_win(32, 8, "R3");
    wr(1'b0, 8'hC0); cyc(2);
    count_win(128, 2, "R3");
    // R2 / R4: unused bits and SLOW mode
    wr(1'b0, 8'hFF);
    rd(1'b0, 8'hE3, "R2");
    cyc(2);
    chk(K_MODE, 1, "R4");
    count_win(100, 10, "R4");
    chk(K_HS, 1, "R6");
    wr(1'b1, 8'hFE); cyc(3);
    rd(1'b1, 8'h00, "R2");
    chk(K_HS, 0, "R6");
    // R9: IDLE1
    pulse_halt(); cyc(3);
    chk(K_MODE, 4, "R9");
    chk(K_HS, 1, "R9");
    chk(K_LS, 1, "R9");
    count_win(50, 0, "R9");
    pulse_halt(); cyc(2);
    chk(K_MODE, 4, "R12");
    pulse_wake(); cyc(2);
    chk(K_MODE, 1, "R11");
    // back to FAST, wake while running
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h00);
    cyc(60);
    count_win(16, 16, "R3");
    pulse_wake(); cyc(2);
    chk(K_MODE, 0, "R12");
    // R7: SLEEP
    pulse_halt(); cyc(3);
    chk(K_MODE, 2, "R7");
    chk(K_HS, 0, "R7");
    chk(K_LS, 0, "R7");
    @(negedge clk); wdt_en = 1'b1; cyc(2);
    chk(K_LS, 1, "R7");
    @(negedge clk); wdt_en = 1'b0; cyc(2);
    pulse_wake();
    count_win(20, 0, "R5");
    cyc(50);
    count_win(16, 16, "R5");
    // R8: IDLE0
    wr(1'b0, 8'h01);
    pulse_halt(); cyc(3);
    chk(K_MODE, 3, "R8");
    chk(K_HS, 0, "R8");
    chk(K_LS, 1, "R8");
    chk(K_PHS, 0, "R13");
    pulse_wake(); cyc(60);
    // R10: IDLE2
    wr(1'b0, 8'h42);
    pulse_halt(); cyc(3);
    chk(K_MODE, 5, "R10");
    chk(K_HS, 1, "R10");
    chk(K_LS, 0, "R10");
    chk(K_PHS, 1, "R13");
    // R11: first CPU enable after wake, divide by 4
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    chk(K_CPU, 0, "R11");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(K_CPU, 0, "R11");
    end
    @(negedge clk);
    chk(K_CPU, 1, "R11");
    chk(K_MODE, 0, "R11");
    cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule